// File: doc/BRIEF.md
# Pulse-Interval Nibble Transmitter

This block sends bytes across a single trigger wire that can carry only edge events. The data rides on the spacing between successive one-clock trigger pulses. Each byte offered on a valid/ready input is cut into two 4-bit nibbles, high nibble first. Each nibble becomes one interval: a fixed holdoff plus a per-step delay multiplied by the nibble value. The pulse that closes the interval marks the symbol.

When no byte is waiting at a byte boundary, the transmitter keeps the line active with an idle interval. That interval uses code 16, which no nibble can produce. A receiver can use it to find which nibble of a pair it is looking at. Queued bytes follow each other with no idle between them. The holdoff and the step size are parameters, and the interval counter is sized so that the idle interval fits.

Top module: `pulseIntervalTx`

## Requirements
- R1: While `rst` is high at a clock edge, `trigOut` and `inReady` are low in the following cycle.
- R2: `trigOut` is never high in two consecutive cycles.
- R3: The number of cycles from one trigger pulse to the next equals HOLDOFF + STEP × code, where code is the nibble value (0 to 15) or 16 for idle.
- R4: No interval between consecutive trigger pulses is shorter than HOLDOFF cycles.
- R5: If no byte is valid at a byte boundary, the next symbol is idle, with an interval of HOLDOFF + 16 × STEP cycles (104 with the defaults).
- R6: An accepted byte is sent as two consecutive symbols: bits 7:4 first, then bits 3:0.
- R7: `inReady` is high for exactly the one cycle before the trigger pulse that ends a symbol, and only when the next symbol starts a byte. A byte is taken in that cycle if `inValid` is high. Each offered byte is taken once, in order.
- R8: Bytes that are valid at each boundary are sent back to back. The cycles between two such acceptances equal the sum of the two nibble intervals of the earlier byte.
- R9: The first symbol after reset is idle. The first pulse comes HOLDOFF + 16 × STEP cycles after the first cycle with `rst` low.
- R10: `inData` has no effect while `inValid` is low. No byte is taken, and only idle intervals appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A byte is offered on inData |
| inData | input | 2*NIB_W (8) | Byte to send |
| inReady | output | 1 | A byte offered now is taken |
| trigOut | output | 1 | One-cycle trigger pulse that ends each symbol |

## Verification
On every cycle, the assertions check the following:
- the trigger is one cycle wide;
- every interval is at least the holdoff, lies on the step grid and fits within the idle length;
- the first interval after reset has the idle length;
- a ready cycle is always followed by a pulse.

The nibble order, the handoff of bytes without a gap, and the fact that `inData` is ignored without `inValid` all depend on the byte values. Only the bench scenarios can show these, by decoding the pulse train back into bytes and comparing it with what was offered.

// File: rtl/pitxPkg.sv
package pitxPkg;

  // Strobes from control to datapath; at most one is high, and only at a symbol end.
  typedef struct packed {
    logic startHigh;  // take the offered byte, time its high nibble next
    logic startLow;   // time the stored low nibble next
    logic startIdle;  // time the idle code next
  } symCmd_t;

endpackage

// File: rtl/pitxDatapath.sv
module pitxDatapath
  import pitxPkg::*;
#(
  parameter int HOLDOFF = 40,
  parameter int STEP    = 4,
  parameter int NIB_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  symCmd_t           cmd,
  input  logic [2*NIB_W-1:0] byteIn,
  output logic              endSym,
  output logic              trigOut
);

  localparam int CODE_W    = NIB_W + 1;
  localparam int IDLE_CODE = 1 << NIB_W;
  localparam int MAX_GAP   = HOLDOFF + STEP * IDLE_CODE;
  localparam int CNT_W     = $clog2(MAX_GAP + 1);
  localparam logic [CNT_W-1:0]  HOLD_C = CNT_W'(HOLDOFF);
  localparam logic [CODE_W-1:0] IDLE_C = CODE_W'(IDLE_CODE);

  logic [CODE_W-1:0] symCode;
  logic [NIB_W-1:0]  lowNib;
  logic [CNT_W-1:0]  gapCnt;
  logic [CNT_W-1:0]  stepSum;
  logic [CNT_W-1:0]  gapTarget;

  // Data-dependent part of the interval: a shift when the step is a power of two.
  generate
    if (STEP > 0 && (STEP & (STEP - 1)) == 0) begin : gShift
      assign stepSum = CNT_W'(symCode) << $clog2(STEP);
    end else begin : gMul
      assign stepSum = CNT_W'(symCode) * CNT_W'(STEP);
    end
  endgenerate

  assign gapTarget = HOLD_C + stepSum;
  assign endSym    = (gapCnt == gapTarget - CNT_W'(1));

  // Interval counter: restarts on the cycle the pulse is launched.
  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt  <= '0;
      trigOut <= 1'b0;
    end else begin
      trigOut <= endSym;
      if (endSym) gapCnt <= '0;
      else        gapCnt <= gapCnt + CNT_W'(1);
    end
  end

  // Symbol register and the low nibble held for the second half of a byte.
  always_ff @(posedge clk) begin
    if (rst) begin
      symCode <= IDLE_C;
      lowNib  <= '0;
    end else if (cmd.startHigh) begin
      symCode <= CODE_W'(byteIn[2*NIB_W-1:NIB_W]);
      lowNib  <= byteIn[NIB_W-1:0];
    end else if (cmd.startLow) begin
      symCode <= CODE_W'(lowNib);
    end else if (cmd.startIdle) begin
      symCode <= IDLE_C;
    end
  end

endmodule

// File: rtl/pitxControl.sv
module pitxControl
  import pitxPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    endSym,
  input  logic    inValid,
  output logic    inReady,
  output symCmd_t cmd
);

  logic phaseLow;  // next symbol to start is the low nibble
  logic accept;

  assign inReady = endSym && !phaseLow;
  assign accept  = inReady && inValid;

  always_comb begin
    cmd           = '0;
    cmd.startHigh = accept;
    cmd.startLow  = endSym && phaseLow;
    cmd.startIdle = inReady && !inValid;
  end

  always_ff @(posedge clk) begin
    if (rst)         phaseLow <= 1'b0;
    else if (endSym) phaseLow <= accept;
  end

endmodule

// File: rtl/pulseIntervalTx.sv
module pulseIntervalTx
  import pitxPkg::*;
#(
  parameter int HOLDOFF = 40,
  parameter int STEP    = 4,
  parameter int NIB_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [2*NIB_W-1:0] inData,
  output logic               inReady,
  output logic               trigOut
);

  symCmd_t symCmd;
  logic    endSym;

  pitxControl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .endSym (endSym),
    .inValid(inValid),
    .inReady(inReady),
    .cmd    (symCmd)
  );

  pitxDatapath #(.HOLDOFF(HOLDOFF), .STEP(STEP), .NIB_W(NIB_W)) uPath (
    .clk    (clk),
    .rst    (rst),
    .cmd    (symCmd),
    .byteIn (inData),
    .endSym (endSym),
    .trigOut(trigOut)
  );

endmodule

// File: rtl/pulseIntervalTxChk.sv
module pulseIntervalTxChk #(
  parameter int HOLDOFF = 40,
  parameter int STEP    = 4,
  parameter int NIB_W   = 4
) (
  input logic clk,
  input logic rst,
  input logic inValid,
  input logic inReady,
  input logic trigOut
);

  localparam int MAX_GAP = HOLDOFF + STEP * (1 << NIB_W);
  localparam int CW      = $clog2(MAX_GAP + 2) + 1;
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  logic [CW-1:0] sinceCnt;  // cycles since the last pulse (or since reset)
  logic          seen;      // a pulse has occurred since reset

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceCnt <= '0;
      seen     <= 1'b0;
    end else begin
      if (trigOut)              sinceCnt <= CW'(1);
      else if (sinceCnt != SAT) sinceCnt <= sinceCnt + CW'(1);
      if (trigOut) seen <= 1'b1;
    end
  end

  a_r2_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    trigOut |=> !trigOut);

  a_r4_min_gap: assert property (@(posedge clk) disable iff (rst)
    (trigOut && seen) |-> (int'(sinceCnt) >= HOLDOFF));

  a_r3_gap_on_grid: assert property (@(posedge clk) disable iff (rst)
    (trigOut && seen) |-> (int'(sinceCnt) <= MAX_GAP &&
                           ((int'(sinceCnt) - HOLDOFF) % STEP) == 0));

  a_r9_first_idle: assert property (@(posedge clk) disable iff (rst)
    (trigOut && !seen) |-> (int'(sinceCnt) == MAX_GAP));

  a_r7_ready_at_boundary: assert property (@(posedge clk) disable iff (rst)
    inReady |=> trigOut);

  a_r7_ready_one_cycle: assert property (@(posedge clk) disable iff (rst)
    inReady |=> !inReady);

  // inValid is part of the observed handshake; keep it referenced.
  logic unusedValid;
  assign unusedValid = inValid;

endmodule

bind pulseIntervalTx pulseIntervalTxChk #(.HOLDOFF(HOLDOFF), .STEP(STEP), .NIB_W(NIB_W)) uChk (
  .clk    (clk),
  .rst    (rst),
  .inValid(inValid),
  .inReady(inReady),
  .trigOut(trigOut)
);

// File: tb/pulseIntervalTx_test.sv
`timescale 1ns/1ps
module pulseIntervalTx_test;

  localparam int HOLD = 40;
  localparam int STP  = 4;
  localparam int IDLE = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inReady;
  logic       trigOut;

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;
  bit garbage = 1'b0;
  bit finished = 1'b0;

  logic [7:0] txq[$];
  logic [7:0] offered[$];
  int         pulseT[$];
  int         hsT[$];
  logic [7:0] hsB[$];

  // behavioural reference state
  int mCnt, mCode, mLow;
  bit mPhaseLow, mTrig, mReady;

  pulseIntervalTx uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .inReady(inReady), .trigOut(trigOut)
  );

  always #2 clk = ~clk;

  function automatic int gapOf(input int code);
    return HOLD + STP * code;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  initial begin
    mCnt = 0; mCode = IDLE; mLow = 0; mPhaseLow = 0; mTrig = 0;
  end

  always @(negedge clk) begin
    bit hs;
    cyc++;
    mReady = (mCnt == gapOf(mCode) - 1) && !mPhaseLow;
    if (cyc == 3) begin
      check(trigOut == 1'b0, "R1 trigOut in reset", int'(trigOut), 0);
      check(inReady == 1'b0, "R1 inReady in reset", int'(inReady), 0);
    end
    if (cyc >= 2) begin
      check(trigOut == mTrig, "R2 R3 trigOut vs model", int'(trigOut), int'(mTrig));
      check(inReady == mReady, "R7 inReady vs model", int'(inReady), int'(mReady));
    end
    if (trigOut) pulseT.push_back(cyc);
    rst = (cyc < 4);
    if (garbage) begin
      inValid = 1'b0;
      inData  = 8'($urandom);
    end else begin
      inValid = (txq.size() > 0);
      inData  = inValid ? txq[0] : 8'h00;
    end
    hs = inValid && mReady && !rst;
    if (hs) begin
      hsT.push_back(cyc);
      hsB.push_back(inData);
      void'(txq.pop_front());
    end
    if (rst) begin
      mCnt = 0; mCode = IDLE; mLow = 0; mPhaseLow = 0; mTrig = 0;
    end else if (mCnt == gapOf(mCode) - 1) begin
      mTrig = 1; mCnt = 0;
      if (mPhaseLow) begin
        mCode = mLow; mPhaseLow = 0;
      end else if (hs) begin
        mCode = int'(inData) / 16; mLow = int'(inData) % 16; mPhaseLow = 1;
      end else begin
        mCode = IDLE;
      end
    end else begin
      mTrig = 0; mCnt++;
    end
  end

  task automatic push(input logic [7:0] b);
    txq.push_back(b);
    offered.push_back(b);
  endtask

  task automatic waitDrain(input int extra);
    while (txq.size() > 0) @(posedge clk);
    repeat (extra) @(posedge clk);
  endtask

  task automatic checkBackToBack(input int first, input int last);
    for (int i = first + 1; i <= last; i++) begin
      int exp;
      exp = gapOf(int'(hsB[i-1]) / 16) + gapOf(int'(hsB[i-1]) % 16);
      check(hsT[i] - hsT[i-1] == exp, "R8 back-to-back spacing", hsT[i] - hsT[i-1], exp);
    end
  endtask

  task automatic finalChecks();
    int codes[$];
    logic [7:0] rebuilt[$];
    int prev;
    check(pulseT.size() > 0, "R9 pulse seen", pulseT.size(), 1);
    if (pulseT.size() == 0) return;
    check(pulseT[0] - 4 == gapOf(IDLE), "R9 first gap idle", pulseT[0] - 4, gapOf(IDLE));
    prev = pulseT[0];
    for (int i = 1; i < pulseT.size(); i++) begin
      int g;
      g = pulseT[i] - prev;
      prev = pulseT[i];
      check(g >= HOLD, "R4 minimum gap", g, HOLD);
      check(((g - HOLD) % STP) == 0 && g <= gapOf(IDLE), "R3 gap on grid", g, HOLD);
      codes.push_back((g - HOLD) / STP);
    end
    for (int i = 0; i < codes.size(); i++) begin
      if (codes[i] == IDLE) continue;
      if (i + 1 < codes.size()) begin
        check(codes[i+1] != IDLE, "R6 low nibble follows high", codes[i+1], 0);
        rebuilt.push_back(8'(codes[i] * 16 + codes[i+1]));
      end
      i++;
    end
    check(hsB.size() == offered.size(), "R7 bytes taken once", hsB.size(), offered.size());
    for (int i = 0; i < offered.size() && i < hsB.size(); i++)
      check(hsB[i] == offered[i], "R7 byte order", int'(hsB[i]), int'(offered[i]));
    check(rebuilt.size() == offered.size(), "R6 decoded count", rebuilt.size(), offered.size());
    for (int i = 0; i < offered.size() && i < rebuilt.size(); i++)
      check(rebuilt[i] == offered[i], "R6 decoded byte high then low",
            int'(rebuilt[i]), int'(offered[i]));
  endtask

  initial begin
    int hsBefore, pulsesBefore, burstStart;
    wait (cyc >= 10);
    // idle only
    wait (cyc >= 420);
    @(posedge clk);
    check(hsT.size() == 0, "R5 no byte while idle", hsT.size(), 0);
    for (int i = 1; i < pulseT.size(); i++)
      check(pulseT[i] - pulseT[i-1] == gapOf(IDLE), "R5 idle interval",
            pulseT[i] - pulseT[i-1], gapOf(IDLE));
    // single byte
    push(8'hA5);
    waitDrain(300);
    // garbage on inData with inValid low
    hsBefore = hsT.size();
    pulsesBefore = pulseT.size();
    garbage = 1'b1;
    repeat (450) @(posedge clk);
    garbage = 1'b0;
    check(hsT.size() == hsBefore, "R10 no byte taken without valid", hsT.size(), hsBefore);
    for (int i = pulsesBefore + 1; i < pulseT.size(); i++)
      check(pulseT[i] - pulseT[i-1] == gapOf(IDLE), "R10 only idle without valid",
            pulseT[i] - pulseT[i-1], gapOf(IDLE));
    // burst with extreme nibbles
    burstStart = hsT.size();
    push(8'h00); push(8'hFF); push(8'h0F); push(8'hF0); push(8'h12); push(8'h3C);
    waitDrain(300);
    checkBackToBack(burstStart, burstStart + 5);
    // ramp across all nibble values
    burstStart = hsT.size();
    for (int i = 0; i < 16; i++) push(8'(i * 16 + (15 - i)));
    waitDrain(400);
    checkBackToBack(burstStart, burstStart + 15);
    finalChecks();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: run did not complete, actual %0d expected %0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule